// File: doc/BRIEF.md
# Flash Suspend/Resume Command Controller

This block holds the suspend and resume bookkeeping for a serial NOR flash device. It is fed one decoded 8-bit opcode at a time. The opcode arrives with a one-cycle valid strobe, raised when the serial frame closes. A one-bit address class comes with it and tells whether the command targets the region of a suspended operation. The block tracks which long operation is in flight and drives the two status flags, `busy` and `sus`. It answers every command with a one-cycle accept or reject pulse. The serial shifter, the array and the real analog timing live elsewhere. The length of each operation is modelled by a countdown loaded from `opLen` when the operation starts.

A running sector erase, block erase, page program or quad page program can be paused. `sus` rises at once, and `busy` drops a fixed `TSUS` cycles later. While the operation is parked, commands that could disturb it are refused. Which commands those are depends on whether an erase or a program was parked. A resume restarts the countdown from where it stopped. After a resume, a new suspend is held off for a minimum spacing. A power-loss strobe wipes all state, including a parked operation.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset or a power-loss strobe, `busy` and `sus` are 0 and neither response pulse is high.
- R2: Every cycle with `cmdValid` high and `pwrLoss` low produces, in the next cycle, exactly one of `cmdAccept` or `cmdReject` for one cycle. No pulse appears without a command.
- R3: When idle, the opcodes that start an operation are accepted and raise `busy` for max(`opLen`,1) cycles, after which `busy` clears. These opcodes are 0x20 (sector erase), 0x52 and 0xD8 (block erase), 0xC7 and 0x60 (chip erase), 0x02 (page program) and 0x32 (quad page program). Other opcodes, apart from 0x75 and 0x7A, are accepted with no state change.
- R4: While `busy` is 1, every opcode other than 0x75 is rejected and the countdown is not disturbed.
- R5: Opcode 0x75 with `busy`=1 and `sus`=0 during a sector erase, block erase, page program or quad page program is accepted. `sus` reads 1 in the next cycle, and `busy` falls exactly `TSUS` clock edges after the accepting edge.
- R6: Opcode 0x75 is rejected with no state change during a chip erase, when the block is idle, and when `sus` is already 1.
- R7: While an erase is suspended, opcodes 0x01, 0x20, 0x52, 0xD8, 0xC7, 0x60 and 0x44 are rejected.
- R8: While a program is suspended, opcodes 0x01, 0x02, 0x32 and 0x42 are rejected.
- R9: While suspended with `busy`=0, any other opcode except 0x75 and 0x7A is accepted when `regionHit`=0 and rejected when `regionHit`=1. In both cases `busy`, `sus` and the parked operation are unchanged.
- R10: Opcode 0x7A is accepted only when `sus`=1 and `busy`=0. It clears `sus`, sets `busy`, and the operation then completes after its remaining count. Otherwise 0x7A is rejected.
- R11: A 0x75 sampled at the `TSUS`-th clock edge after an accepted resume is rejected. One sampled at the (`TSUS`+1)-th edge is accepted.
- R12: A power-loss strobe during a suspension drops the parked operation, so a later 0x7A is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrLoss | input | 1 | Synchronous power-loss strobe, clears all state |
| cmdValid | input | 1 | Opcode valid strobe, one cycle per command |
| cmdOp | input | 8 | Decoded opcode |
| regionHit | input | 1 | Command targets the region of the parked operation |
| opLen | input | CNT_W | Countdown length loaded when an operation starts |
| busy | output | 1 | Operation in progress |
| sus | output | 1 | Operation suspended |
| cmdAccept | output | 1 | One-cycle accept pulse |
| cmdReject | output | 1 | One-cycle reject pulse |

## Verification
The bench aims at the exact cycle `busy` falls after a suspend, and at the remaining count carried across a resume. A design that kept counting during the suspend latency, or lost a count at the suspend edge, would drop `busy` early. It probes the resume spacing on both sides of the boundary, where an off-by-one would accept a suspend too soon or refuse a legal one. It sends each forbidden opcode for both erase and program suspensions, plus a suspend during chip erase. A mixed-up table would accept a forbidden command or start a second operation. Power loss during a suspension is followed by a resume, which a design that kept the parked context would wrongly accept.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    OK_NONE  = 3'd0,
    OK_SECT  = 3'd1,
    OK_BLK   = 3'd2,
    OK_CHIP  = 3'd3,
    OK_PAGE  = 3'd4,
    OK_QPAGE = 3'd5
  } opKind_e;

  localparam logic [7:0] OPC_SUSPEND = 8'h75;
  localparam logic [7:0] OPC_RESUME  = 8'h7A;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    clearAll;
    logic    startOp;
    opKind_e startKind;
    logic    suspend;
    logic    resume;
    logic    respAcc;
    logic    respRej;
  } ctlStrobe_t;

  function automatic opKind_e kindOfOpcode(input logic [7:0] op);
    case (op)
      8'h20:        return OK_SECT;
      8'h52, 8'hD8: return OK_BLK;
      8'hC7, 8'h60: return OK_CHIP;
      8'h02:        return OK_PAGE;
      8'h32:        return OK_QPAGE;
      default:      return OK_NONE;
    endcase
  endfunction

  function automatic logic canSuspend(input opKind_e k);
    return (k == OK_SECT) || (k == OK_BLK) || (k == OK_PAGE) || (k == OK_QPAGE);
  endfunction

  function automatic logic isEraseKind(input opKind_e k);
    return (k == OK_SECT) || (k == OK_BLK) || (k == OK_CHIP);
  endfunction

  function automatic logic bannedInEraseSusp(input logic [7:0] op);
    case (op)
      8'h01, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h44: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic bannedInProgSusp(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h32, 8'h42: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fsr_ctl.sv
module fsr_ctl
  import fsr_pkg::*;
(
  input  logic       pwrLoss,
  input  logic       cmdValid,
  input  logic [7:0] cmdOp,
  input  logic       regionHit,
  input  logic       busy,
  input  logic       sus,
  input  opKind_e    curKind,
  input  logic       gapOpen,
  output ctlStrobe_t str
);

  logic banned;

  always_comb begin
    if (isEraseKind(curKind)) banned = bannedInEraseSusp(cmdOp);
    else                      banned = bannedInProgSusp(cmdOp);
  end

  always_comb begin
    str = '0;
    if (pwrLoss) begin
      str.clearAll = 1'b1;
    end else if (cmdValid) begin
      if (busy) begin
        // running or still inside the suspend latency
        if (cmdOp == OPC_SUSPEND && !sus && canSuspend(curKind) && gapOpen) begin
          str.suspend = 1'b1;
          str.respAcc = 1'b1;
        end else begin
          str.respRej = 1'b1;
        end
      end else if (sus) begin
        if (cmdOp == OPC_RESUME) begin
          str.resume  = 1'b1;
          str.respAcc = 1'b1;
        end else if (banned || cmdOp == OPC_SUSPEND || regionHit) begin
          str.respRej = 1'b1;
        end else begin
          str.respAcc = 1'b1;
        end
      end else begin
        if (cmdOp == OPC_SUSPEND || cmdOp == OPC_RESUME) begin
          str.respRej = 1'b1;
        end else begin
          str.respAcc   = 1'b1;
          str.startKind = kindOfOpcode(cmdOp);
          str.startOp   = (kindOfOpcode(cmdOp) != OK_NONE);
        end
      end
    end
  end

endmodule

// File: rtl/fsr_dp.sv
module fsr_dp
  import fsr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TSUS  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       str,
  input  logic [CNT_W-1:0] opLen,
  output logic             busy,
  output logic             sus,
  output opKind_e          curKind,
  output logic             gapOpen,
  output logic             accPulse,
  output logic             rejPulse
);

  localparam int LAT_W = $clog2(TSUS + 1);

  logic [CNT_W-1:0] remQ;
  logic [LAT_W-1:0] latQ;
  logic [LAT_W-1:0] gapQ;
  logic             running;

  // the countdown freezes on the edge a suspend is taken
  assign running = busy && !sus && !str.suspend;
  assign gapOpen = (gapQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sus      <= 1'b0;
      curKind  <= OK_NONE;
      remQ     <= '0;
      latQ     <= '0;
      gapQ     <= '0;
      accPulse <= 1'b0;
      rejPulse <= 1'b0;
    end else if (str.clearAll) begin
      busy     <= 1'b0;
      sus      <= 1'b0;
      curKind  <= OK_NONE;
      remQ     <= '0;
      latQ     <= '0;
      gapQ     <= '0;
      accPulse <= 1'b0;
      rejPulse <= 1'b0;
    end else begin
      accPulse <= str.respAcc;
      rejPulse <= str.respRej;
      if (gapQ != '0) gapQ <= gapQ - 1'b1;

      if (str.startOp) begin
        busy    <= 1'b1;
        curKind <= str.startKind;
        remQ    <= (opLen == '0) ? CNT_W'(1) : opLen;
      end else if (str.suspend) begin
        sus  <= 1'b1;
        latQ <= LAT_W'(TSUS);
      end else if (str.resume) begin
        sus  <= 1'b0;
        busy <= 1'b1;
        gapQ <= LAT_W'(TSUS);
      end else if (running) begin
        if (remQ == CNT_W'(1)) begin
          busy    <= 1'b0;
          curKind <= OK_NONE;
          remQ    <= '0;
        end else begin
          remQ <= remQ - 1'b1;
        end
      end else if (sus && latQ != '0) begin
        latQ <= latQ - 1'b1;
        if (latQ == LAT_W'(1)) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
  import fsr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TSUS  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrLoss,
  input  logic             cmdValid,
  input  logic [7:0]       cmdOp,
  input  logic             regionHit,
  input  logic [CNT_W-1:0] opLen,
  output logic             busy,
  output logic             sus,
  output logic             cmdAccept,
  output logic             cmdReject
);

  ctlStrobe_t str;
  opKind_e    curKind;
  logic       gapOpen;

  fsr_ctl u_ctl (
    .pwrLoss   (pwrLoss),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .regionHit (regionHit),
    .busy      (busy),
    .sus       (sus),
    .curKind   (curKind),
    .gapOpen   (gapOpen),
    .str       (str)
  );

  fsr_dp #(.CNT_W(CNT_W), .TSUS(TSUS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .opLen    (opLen),
    .busy     (busy),
    .sus      (sus),
    .curKind  (curKind),
    .gapOpen  (gapOpen),
    .accPulse (cmdAccept),
    .rejPulse (cmdReject)
  );

endmodule

// File: rtl/fsr_chk.sv
module fsr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrLoss,
  input logic       cmdValid,
  input logic [7:0] cmdOp,
  input logic       busy,
  input logic       sus,
  input logic       cmdAccept,
  input logic       cmdReject
);

  p_resp_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  p_resp_cause_r2: assert property (@(posedge clk) disable iff (!rstN || pwrLoss)
    (cmdAccept || cmdReject) |-> $past(cmdValid));

  p_busy_rejects_r4: assert property (@(posedge clk) disable iff (!rstN || pwrLoss)
    (cmdValid && busy && cmdOp != 8'h75) |=> cmdReject);

  p_sus_rise_r5: assert property (@(posedge clk) disable iff (!rstN || pwrLoss)
    $rose(sus) |-> $past(cmdValid && cmdOp == 8'h75 && busy));

  p_idle_suspend_r6: assert property (@(posedge clk) disable iff (!rstN || pwrLoss)
    (cmdValid && !busy && !sus && cmdOp == 8'h75) |=> (cmdReject && !busy && !sus));

  p_sus_fall_r10: assert property (@(posedge clk) disable iff (!rstN || pwrLoss)
    ($fell(sus) && !$past(pwrLoss)) |-> (busy && $past(cmdValid && cmdOp == 8'h7A)));

  p_pwr_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    pwrLoss |=> (!busy && !sus && !cmdAccept && !cmdReject));

endmodule

bind flash_susp_ctrl fsr_chk u_fsr_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pwrLoss   (pwrLoss),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .busy      (busy),
  .sus       (sus),
  .cmdAccept (cmdAccept),
  .cmdReject (cmdReject)
);

// File: tb/test_flash_susp_ctrl.sv
`timescale 1ns/1ps
module test_flash_susp_ctrl;

  localparam int CNT_W = 16;
  localparam int TSUS  = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pwrLoss = 1'b0;
  logic             cmdValid = 1'b0;
  logic [7:0]       cmdOp = 8'h00;
  logic             regionHit = 1'b0;
  logic [CNT_W-1:0] opLen = '0;
  logic             busy, sus, cmdAccept, cmdReject;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  bit    expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  flash_susp_ctrl #(.CNT_W(CNT_W), .TSUS(TSUS)) i_flash_susp_ctrl (
    .clk(clk), .rstN(rstN), .pwrLoss(pwrLoss), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .regionHit(regionHit), .opLen(opLen),
    .busy(busy), .sus(sus), .cmdAccept(cmdAccept), .cmdReject(cmdReject)
  );

  // monitor: pops one expected response per observed pulse (R2)
  always @(negedge clk) begin
    if (rstN && (cmdAccept || cmdReject)) begin
      nChecks++;
      if (cmdAccept && cmdReject) begin
        nFail++;
        $display("FAIL R2 both pulses high: acc=%0b rej=%0b expected one", cmdAccept, cmdReject);
      end else if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R2 unexpected response acc=%0b expected none", cmdAccept);
      end else begin
        bit    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (cmdAccept != e) begin
          nFail++;
          $display("FAIL %s response acc=%0b expected acc=%0b", t, cmdAccept, e);
        end
      end
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one command at a negedge; returns at the negedge after it was sampled
  task automatic issue(input logic [7:0] op, input logic hit, input bit expAcc, input string tag);
    expQ.push_back(expAcc);
    tagQ.push_back(tag);
    cmdOp     = op;
    regionHit = hit;
    cmdValid  = 1'b1;
    @(negedge clk);
    cmdValid  = 1'b0;
    regionHit = 1'b0;
  endtask

  task automatic chkStat(input bit eBusy, input bit eSus, input string tag);
    nChecks++;
    if (busy !== eBusy || sus !== eSus) begin
      nFail++;
      $display("FAIL %s busy=%0b sus=%0b expected busy=%0b sus=%0b", tag, busy, sus, eBusy, eSus);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired busy=%0b sus=%0b expected run to finish", busy, sus);
      summary();
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1: reset state
    chkStat(0, 0, "R1 reset");
    nChecks++;
    if (cmdAccept || cmdReject) begin
      nFail++;
      $display("FAIL R1 pulses acc=%0b rej=%0b expected 0", cmdAccept, cmdReject);
    end

    // R6/R10: idle ignores suspend and resume; R3: other opcode accepted
    issue(8'h75, 0, 0, "R6 idle suspend");
    issue(8'h7A, 0, 0, "R10 idle resume");
    issue(8'h03, 0, 1, "R3 idle read");
    chkStat(0, 0, "R6 idle unchanged");

    // R3: page program length 5
    opLen = 16'd5;
    issue(8'h02, 0, 1, "R3 page start");
    chkStat(1, 0, "R3 page busy");
    waitN(4);
    chkStat(1, 0, "R3 page last cycle");
    waitN(1);
    chkStat(0, 0, "R3 page done");

    // R4/R5: sector erase length 20, suspend
    opLen = 16'd20;
    issue(8'h20, 0, 1, "R3 sector start");
    issue(8'h03, 0, 0, "R4 busy reject");
    chkStat(1, 0, "R4 busy unchanged");
    issue(8'h75, 0, 1, "R5 suspend sector");
    chkStat(1, 1, "R5 sus immediate");
    issue(8'h75, 0, 0, "R6 suspend when sus");
    waitN(4);
    chkStat(1, 1, "R5 busy held in latency");
    waitN(1);
    chkStat(0, 1, "R5 busy drops after TSUS");

    // R7: erase-suspend bans
    issue(8'h01, 0, 0, "R7 ban 01");
    issue(8'h20, 0, 0, "R7 ban 20");
    issue(8'h52, 0, 0, "R7 ban 52");
    issue(8'hD8, 0, 0, "R7 ban D8");
    issue(8'hC7, 0, 0, "R7 ban C7");
    issue(8'h60, 0, 0, "R7 ban 60");
    issue(8'h44, 0, 0, "R7 ban 44");
    chkStat(0, 1, "R7 state kept");
    // R9: allowed command, region checks
    issue(8'h02, 0, 1, "R9 program elsewhere");
    issue(8'h03, 1, 0, "R9 hit parked region");
    chkStat(0, 1, "R9 state kept");

    // R10: resume, remaining 19 cycles
    issue(8'h7A, 0, 1, "R10 resume");
    chkStat(1, 0, "R10 resumed");
    waitN(18);
    chkStat(1, 0, "R10 remaining count");
    waitN(1);
    chkStat(0, 0, "R10 complete");

    // R11: spacing after resume, block erase
    opLen = 16'd100;
    issue(8'hD8, 0, 1, "R3 block start");
    issue(8'h75, 0, 1, "R5 suspend block");
    waitN(6);
    chkStat(0, 1, "R5 block suspended");
    issue(8'h7A, 0, 1, "R10 resume block");
    waitN(TSUS - 1);
    issue(8'h75, 0, 0, "R11 suspend too soon");
    chkStat(1, 0, "R11 still running");
    issue(8'h75, 0, 1, "R11 suspend at spacing");
    chkStat(1, 1, "R11 suspended");
    waitN(6);
    chkStat(0, 1, "R11 parked");

    // R12: power loss during suspension
    pwrLoss = 1'b1;
    waitN(1);
    pwrLoss = 1'b0;
    chkStat(0, 0, "R12 power loss clears");
    issue(8'h7A, 0, 0, "R12 resume after loss");
    chkStat(0, 0, "R12 nothing resumed");

    // R8/R9: quad page program suspend
    opLen = 16'd50;
    issue(8'h32, 0, 1, "R3 quad start");
    issue(8'h75, 0, 1, "R5 suspend quad");
    waitN(6);
    chkStat(0, 1, "R5 quad suspended");
    issue(8'h01, 0, 0, "R8 ban 01");
    issue(8'h02, 0, 0, "R8 ban 02");
    issue(8'h32, 0, 0, "R8 ban 32");
    issue(8'h42, 0, 0, "R8 ban 42");
    issue(8'h20, 0, 1, "R9 erase op allowed");
    chkStat(0, 1, "R9 quad state kept");
    issue(8'h7A, 0, 1, "R10 resume quad");
    waitN(49);
    chkStat(1, 0, "R10 quad remaining");
    waitN(1);
    chkStat(0, 0, "R10 quad complete");

    // R6: chip erase cannot be suspended
    opLen = 16'd10;
    issue(8'hC7, 0, 1, "R3 chip start");
    issue(8'h75, 0, 0, "R6 chip suspend");
    chkStat(1, 0, "R6 chip unchanged");
    waitN(8);
    chkStat(1, 0, "R6 chip still running");
    waitN(1);
    chkStat(0, 0, "R6 chip done");

    // R3: zero length treated as one cycle
    opLen = 16'd0;
    issue(8'h52, 0, 1, "R3 zero length start");
    chkStat(1, 0, "R3 zero length busy");
    waitN(1);
    chkStat(0, 0, "R3 zero length done");

    waitN(3);
    nChecks++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R2 missing responses: %0d expected 0", expQ.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule